// File: doc/BRIEF.md
# Real-Time Clock Calendar Register Set

This block keeps the time of day and the date of a real-time clock: seconds, minutes, hours, weekday, day of month, month, two-digit year and a century byte. A one-cycle pulse on the one-second tick input moves the time forward by one second. Carries ripple from seconds through minutes, hours and the day fields up to the century.

Software reaches the block through a simple byte-wide port. A write is a one-cycle strobe with an address and data. A read is a combinational mux on the read address, with a strobe that marks the read as taken. A control byte holds two bits. One chooses whether the stored values are counted as packed BCD or as plain binary. The other is a freeze bit that stops the time from advancing while software loads new values.

Each advance raises an update flag and a summary interrupt flag. Both are visible on output pins and in a flag byte, and reading that byte clears them. A status byte always shows that the time and the RAM are valid.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the time bytes read seconds 0x00, minutes 0x00, hours 0x00, weekday 0x01, day 0x01, month 0x01, year 0x00 and century 0x20. The control byte reads 0x00 and both flags are clear. Addresses are 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day, 5 month, 6 year, 7 century, 8 control, 9 flags and 10 status.
- R2: When control bit 2 is 1 (binary mode), each tick with the freeze bit clear adds one to the seconds byte as a binary number.
- R3: When control bit 2 is 0 (BCD mode), counting uses packed BCD, with the tens digit in bits 7:4 and the units digit in bits 3:0. For example, 0x09 steps to 0x10.
- R4: Seconds wrap from 59 to 0 and carry into minutes. Minutes wrap from 59 to 0 and carry into hours. Hours wrap from 23 to 0 and carry into the weekday and the day of month.
- R5: The weekday counts 1 to 7 and steps from 7 back to 1 on a day carry.
- R6: The day of month wraps to 1 and carries into the month after the month's last day. Months 4, 6, 9 and 11 have 30 days and the other months have 31. February has 29 days when the year is divisible by 4 and 28 days otherwise.
- R7: The month steps from 12 to 1 and carries into the year. The year steps from 99 to 0 and adds one to the century byte.
- R8: While control bit 7 (freeze) is 1, ticks leave every time byte unchanged and raise no flag, and bytes that software writes hold their values. A software write to a time byte always takes effect.
- R9: Each tick that advances the time sets the update flag (flag byte bit 4, and the update flag pin) and the summary flag (flag byte bit 7, and the interrupt flag pin). A read of the flag byte with the read strobe returns the flags and clears them on the next clock edge.
- R10: The status byte always reads 0x80 (bit 7 means time valid).
- R11: Changing control bit 2 does not convert the stored bytes. They read back unchanged, and later counting treats them in the new mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_1s | input | 1 | One-cycle pulse once per second |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe; clears the flags when it addresses the flag byte |
| rd_addr | input | 4 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| upd_o | output | 1 | Update-ended flag |
| irq_o | output | 1 | Summary interrupt flag |

## Verification
The assertions check, on every cycle, the behaviour that holds cycle by cycle. The status byte always shows its valid bit. Every advancing tick raises both flags. A read of the flag byte clears them. The freeze bit holds all time bytes steady. In binary mode, a seconds value below 59 steps up by exactly one.

Only the bench scenarios can show the full carry chain and the calendar rules. These include the 30-day and 31-day months, February in leap and non-leap years, and the year and century wrap in BCD. The bench also shows that a mode change leaves stored bytes unconverted and that they later count in the new encoding.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned ADDR_W   = 4;
  localparam int unsigned NUM_TIME = 8;
  localparam int unsigned IDX_W    = $clog2(NUM_TIME);

  // time byte slots
  localparam int unsigned I_SEC  = 0;
  localparam int unsigned I_MIN  = 1;
  localparam int unsigned I_HOUR = 2;
  localparam int unsigned I_WDAY = 3;
  localparam int unsigned I_MDAY = 4;
  localparam int unsigned I_MON  = 5;
  localparam int unsigned I_YEAR = 6;
  localparam int unsigned I_CENT = 7;

  // control, flag and status addresses
  localparam logic [ADDR_W-1:0] A_CTRL = 4'd8;
  localparam logic [ADDR_W-1:0] A_FLAG = 4'd9;
  localparam logic [ADDR_W-1:0] A_STAT = 4'd10;

  localparam int unsigned CTRL_FREEZE = 7;
  localparam int unsigned CTRL_BIN    = 2;
  localparam int unsigned FLAG_SUM    = 7;
  localparam int unsigned FLAG_UPD    = 4;
  localparam logic [DATA_W-1:0] STAT_VALUE = 8'h80;

  typedef logic [NUM_TIME-1:0][DATA_W-1:0] time_vec_t;

  // stored byte to binary count value
  function automatic logic [DATA_W-1:0] fmt_to_bin(logic [DATA_W-1:0] v, logic bcd);
    return bcd ? (({4'd0, v[7:4]} * 8'd10) + {4'd0, v[3:0]}) : v;
  endfunction

  // binary count value (below 100) to stored byte
  function automatic logic [DATA_W-1:0] bin_to_fmt(logic [DATA_W-1:0] b, logic bcd);
    return bcd ? (((b / 8'd10) << 4) | (b % 8'd10)) : b;
  endfunction
endpackage

// File: rtl/rtc_rst_sync.sv
module rtc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_ns = sync_q[STAGES-1];
endmodule

// File: rtl/rtc_cal_advance.sv
module rtc_cal_advance
  import rtc_cal_pkg::*;
(
  input  time_vec_t cur_i,
  input  logic      bcd_i,
  output time_vec_t nxt_o
);
  logic [NUM_TIME-1:0][DATA_W-1:0] b_cur;
  logic [NUM_TIME-1:0][DATA_W-1:0] b_nxt;

  for (genvar g = 0; g < NUM_TIME; g++) begin : g_decode
    assign b_cur[g] = fmt_to_bin(cur_i[g], bcd_i);
    assign nxt_o[g] = bin_to_fmt(b_nxt[g], bcd_i);
  end

  logic             c_min, c_hour, c_day, c_mon, c_year, c_cent;
  logic [DATA_W-1:0] mlen;
  logic              leap;

  always_comb begin
    leap = (b_cur[I_YEAR][1:0] == 2'b00);
    case (b_cur[I_MON])
      8'd2:                     mlen = leap ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:  mlen = 8'd30;
      default:                  mlen = 8'd31;
    endcase

    c_min  = (b_cur[I_SEC]  >= 8'd59);
    c_hour = c_min  && (b_cur[I_MIN]  >= 8'd59);
    c_day  = c_hour && (b_cur[I_HOUR] >= 8'd23);
    c_mon  = c_day  && (b_cur[I_MDAY] >= mlen);
    c_year = c_mon  && (b_cur[I_MON]  >= 8'd12);
    c_cent = c_year && (b_cur[I_YEAR] >= 8'd99);

    b_nxt = b_cur;
    b_nxt[I_SEC] = c_min ? 8'd0 : b_cur[I_SEC] + 8'd1;
    if (c_min)  b_nxt[I_MIN]  = c_hour ? 8'd0 : b_cur[I_MIN] + 8'd1;
    if (c_hour) b_nxt[I_HOUR] = c_day  ? 8'd0 : b_cur[I_HOUR] + 8'd1;
    if (c_day) begin
      b_nxt[I_WDAY] = (b_cur[I_WDAY] >= 8'd7 || b_cur[I_WDAY] == 8'd0) ? 8'd1
                                                                       : b_cur[I_WDAY] + 8'd1;
      b_nxt[I_MDAY] = c_mon ? 8'd1 : b_cur[I_MDAY] + 8'd1;
    end
    if (c_mon)  b_nxt[I_MON]  = c_year ? 8'd1 : b_cur[I_MON] + 8'd1;
    if (c_year) b_nxt[I_YEAR] = c_cent ? 8'd0 : b_cur[I_YEAR] + 8'd1;
    if (c_cent) b_nxt[I_CENT] = (b_cur[I_CENT] >= 8'd99) ? 8'd0 : b_cur[I_CENT] + 8'd1;
  end
endmodule

// File: rtl/rtc_cal_flags.sv
module rtc_cal_flags (
  input  logic clk,
  input  logic rst_ns,
  input  logic set_i,
  input  logic clr_i,
  output logic upd_o,
  output logic irq_o
);
  logic upd_q, upd_d, irq_q, irq_d, flg_en;

  always_comb begin
    flg_en = set_i | clr_i;
    upd_d  = set_i;
    irq_d  = set_i;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      upd_q <= 1'b0;
      irq_q <= 1'b0;
    end else if (flg_en) begin
      upd_q <= upd_d;
      irq_q <= irq_d;
    end
  end

  assign upd_o = upd_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_cal_pkg::*;
#(
  parameter logic [DATA_W-1:0] RESET_CENTURY = 8'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1s,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              upd_o,
  output logic              irq_o
);
  logic        rst_ns;
  time_vec_t   time_q, time_d, time_adv;
  logic [DATA_W-1:0] ctrl_q, ctrl_d;
  logic        adv, wr_time, wr_ctrl, time_en, flag_clr;
  logic        flag_upd, flag_irq;

  rtc_rst_sync #(.STAGES(2)) u_rst (.clk(clk), .rst_n(rst_n), .rst_ns(rst_ns));

  rtc_cal_advance u_adv (
    .cur_i (time_q),
    .bcd_i (~ctrl_q[CTRL_BIN]),
    .nxt_o (time_adv)
  );

  always_comb begin
    adv      = tick_1s & ~ctrl_q[CTRL_FREEZE];
    wr_time  = wr_en & (wr_addr < ADDR_W'(NUM_TIME));
    wr_ctrl  = wr_en & (wr_addr == A_CTRL);
    time_en  = adv | wr_time;
    flag_clr = rd_en & (rd_addr == A_FLAG);
    time_d   = adv ? time_adv : time_q;
    if (wr_time) time_d[wr_addr[IDX_W-1:0]] = wr_data;
    ctrl_d   = wr_data;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      time_q          <= '0;
      time_q[I_WDAY]  <= 8'h01;
      time_q[I_MDAY]  <= 8'h01;
      time_q[I_MON]   <= 8'h01;
      time_q[I_CENT]  <= RESET_CENTURY;
    end else if (time_en) begin
      time_q <= time_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)      ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= ctrl_d;
  end

  rtc_cal_flags u_flg (
    .clk(clk), .rst_ns(rst_ns), .set_i(adv), .clr_i(flag_clr),
    .upd_o(flag_upd), .irq_o(flag_irq)
  );

  always_comb begin
    rd_data = '0;
    if (rd_addr < ADDR_W'(NUM_TIME)) rd_data = time_q[rd_addr[IDX_W-1:0]];
    else if (rd_addr == A_CTRL)      rd_data = ctrl_q;
    else if (rd_addr == A_FLAG) begin
      rd_data[FLAG_SUM] = flag_irq;
      rd_data[FLAG_UPD] = flag_upd;
    end
    else if (rd_addr == A_STAT)      rd_data = STAT_VALUE;
  end

  assign upd_o = flag_upd;
  assign irq_o = flag_irq;
endmodule

// File: rtl/rtc_cal_chk.sv
module rtc_cal_chk
  import rtc_cal_pkg::*;
(
  input logic              clk,
  input logic              rst_ns,
  input logic              tick_1s,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic [DATA_W-1:0] ctrl_q,
  input time_vec_t         time_q,
  input logic              upd_o,
  input logic              irq_o
);
  logic adv_c;
  assign adv_c = tick_1s & ~ctrl_q[CTRL_FREEZE];

  p_status_valid_r10: assert property (@(posedge clk) disable iff (!rst_ns)
    (rd_addr == A_STAT) |-> (rd_data == STAT_VALUE));

  p_flag_raise_r9: assert property (@(posedge clk) disable iff (!rst_ns)
    adv_c |=> (upd_o && irq_o));

  p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rst_ns)
    (rd_en && rd_addr == A_FLAG && !adv_c) |=> (!upd_o && !irq_o));

  p_freeze_hold_r8: assert property (@(posedge clk) disable iff (!rst_ns)
    (ctrl_q[CTRL_FREEZE] && !wr_en) |=> $stable(time_q));

  p_sec_step_r2: assert property (@(posedge clk) disable iff (!rst_ns)
    (adv_c && !wr_en && ctrl_q[CTRL_BIN] && time_q[I_SEC] < 8'd59)
    |=> (time_q[I_SEC] == $past(time_q[I_SEC]) + 8'd1));
endmodule

bind rtc_calendar rtc_cal_chk u_chk (
  .clk(clk), .rst_ns(rst_ns), .tick_1s(tick_1s), .wr_en(wr_en),
  .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
  .ctrl_q(ctrl_q), .time_q(time_q), .upd_o(upd_o), .irq_o(irq_o)
);

// File: tb/sim_rtc_calendar.sv
module sim_rtc_calendar;
  localparam logic [3:0] AS = 4'd0, AM = 4'd1, AH = 4'd2, AW = 4'd3,
                         AD = 4'd4, AMO = 4'd5, AY = 4'd6, AC = 4'd7,
                         ACTL = 4'd8, AFLG = 4'd9, ASTA = 4'd10;
  localparam logic [7:0] MODE_BIN = 8'h04, MODE_BCD = 8'h00, FREEZE = 8'h80;

  logic clk = 1'b0, rst_n = 1'b0, tick_1s = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic upd_o, irq_o;
  int   n_chk = 0, n_bad = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  rtc_calendar u0 (.clk(clk), .rst_n(rst_n), .tick_1s(tick_1s), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .upd_o(upd_o), .irq_o(irq_o));

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); tick_1s = 1'b1;
    @(negedge clk); tick_1s = 1'b0;
  endtask

  task automatic peek(input logic [3:0] a, output logic [7:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic rd_clear(output logic [7:0] d);
    @(negedge clk); rd_addr = AFLG; rd_en = 1'b1; #1; d = rd_data;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic expect_reg(input string req, input logic [3:0] a, input logic [7:0] e);
    logic [7:0] v;
    peek(a, v); check(req, v, e);
  endtask

  task automatic load(input logic [7:0] s, m, h, w, d, mo, y, c);
    wr(AS, s); wr(AM, m); wr(AH, h); wr(AW, w);
    wr(AD, d); wr(AMO, mo); wr(AY, y); wr(AC, c);
  endtask

  task automatic t_reset();
    expect_reg("R1 sec", AS, 8'h00);  expect_reg("R1 min", AM, 8'h00);
    expect_reg("R1 hour", AH, 8'h00); expect_reg("R1 wday", AW, 8'h01);
    expect_reg("R1 mday", AD, 8'h01); expect_reg("R1 mon", AMO, 8'h01);
    expect_reg("R1 year", AY, 8'h00); expect_reg("R1 cent", AC, 8'h20);
    expect_reg("R1 ctrl", ACTL, 8'h00); expect_reg("R1 flags", AFLG, 8'h00);
    expect_reg("R10 status", ASTA, 8'h80);
  endtask

  task automatic t_binary_rollover();
    logic [7:0] f;
    wr(ACTL, MODE_BIN);
    load(8'd58, 8'd59, 8'd23, 8'd7, 8'd28, 8'd2, 8'd23, 8'd20);
    rd_clear(f);
    tick();
    expect_reg("R2 sec step", AS, 8'd59);
    check("R9 upd pin", {7'd0, upd_o}, 8'd1);
    check("R9 irq pin", {7'd0, irq_o}, 8'd1);
    tick();
    expect_reg("R4 sec wrap", AS, 8'd0);  expect_reg("R4 min wrap", AM, 8'd0);
    expect_reg("R4 hour wrap", AH, 8'd0); expect_reg("R5 wday wrap", AW, 8'd1);
    expect_reg("R6 feb28 nonleap", AD, 8'd1); expect_reg("R6 to march", AMO, 8'd3);
  endtask

  task automatic t_leap();
    load(8'd59, 8'd59, 8'd23, 8'd3, 8'd28, 8'd2, 8'd24, 8'd20);
    tick();
    expect_reg("R6 leap feb29", AD, 8'd29); expect_reg("R6 leap stays feb", AMO, 8'd2);
    expect_reg("R5 wday step", AW, 8'd4);
    wr(AS, 8'd59); wr(AM, 8'd59); wr(AH, 8'd23);
    tick();
    expect_reg("R6 leap to day1", AD, 8'd1); expect_reg("R6 leap to march", AMO, 8'd3);
  endtask

  task automatic t_bcd();
    wr(ACTL, MODE_BCD);
    wr(AS, 8'h09); tick();
    expect_reg("R3 bcd 09->10", AS, 8'h10);
    load(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99, 8'h20);
    tick();
    expect_reg("R3 bcd sec", AS, 8'h00);  expect_reg("R3 bcd hour", AH, 8'h00);
    expect_reg("R7 mday", AD, 8'h01);     expect_reg("R7 mon 12->1", AMO, 8'h01);
    expect_reg("R7 year 99->0", AY, 8'h00); expect_reg("R7 century", AC, 8'h21);
    load(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h04, 8'h25, 8'h20);
    tick();
    expect_reg("R6 april30", AD, 8'h01); expect_reg("R6 to may", AMO, 8'h05);
    load(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h05, 8'h25, 8'h20);
    tick();
    expect_reg("R6 may30", AD, 8'h31); expect_reg("R6 stays may", AMO, 8'h05);
  endtask

  task automatic t_freeze();
    logic [7:0] f;
    wr(ACTL, FREEZE | MODE_BCD);
    rd_clear(f);
    wr(AS, 8'h15); wr(AM, 8'h42);
    tick(); tick(); tick();
    expect_reg("R8 frozen sec", AS, 8'h15); expect_reg("R8 frozen min", AM, 8'h42);
    expect_reg("R8 no flag", AFLG, 8'h00);
    wr(ACTL, MODE_BCD);
    tick();
    expect_reg("R8 resume", AS, 8'h16);
  endtask

  task automatic t_flags();
    logic [7:0] f;
    tick();
    rd_clear(f);
    check("R9 flag byte", f, 8'h90);
    expect_reg("R9 cleared", AFLG, 8'h00);
    check("R9 upd pin clear", {7'd0, upd_o}, 8'd0);
  endtask

  task automatic t_mode_change();
    wr(ACTL, MODE_BCD); wr(AS, 8'h19);
    wr(ACTL, MODE_BIN);
    expect_reg("R11 no convert", AS, 8'h19);
    tick();
    expect_reg("R11 counts binary", AS, 8'h1A);
    expect_reg("R10 status again", ASTA, 8'h80);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_binary_rollover();
    t_leap();
    t_bcd();
    t_freeze();
    t_flags();
    t_mode_change();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule